// File: doc/BRIEF.md
# USB Controller Interrupt Shadow with End-of-Interrupt Re-arm

This block sits between a USB controller core and a CPU and collects every interrupt event of the core into one 32-bit source register. The fields are transmit events for endpoint 0 and four transmit endpoints, receive events for endpoints 1 to 4, and nine core-level events. Software never writes the source or mask registers directly. Each register has its own write-one-to-set port and its own write-one-to-clear port, so software can change single bits without a read-modify-write. Software can also force any source bit, for example the VBUS-drive-change event, to start its own polling.

A masked view, the source ANDed with the mask, is readable at its own address. An interrupt handler reads the masked view and writes the same value to the source-clear port to acknowledge those bits. It then writes the end-of-interrupt register to re-arm the CPU line. The CPU line is a one-cycle pulse. Once it has fired it stays low until an end-of-interrupt write arrives, whatever data that write carries. Access is through a simple register bus: byte address, write enable, write data and combinational read data.

Top module: `usb_irq_shadow`

## Requirements
- R1: After a synchronous active-low reset, the source and mask registers read zero, `cpu_irq` is low, and the line is armed, so the first masked pending bit fires it.
- R2: Bit layout of the source register. A one-cycle pulse on `tx_evt[i]` sets bit i (bits 4..0). A pulse on `rx_evt[j]`, for receive endpoint j+1, sets bit 9+j (bits 12..9). A pulse on `core_evt[k]` sets bit 16+k (bits 24..16), and bit 24 is the VBUS-drive-change event. A set bit stays set until it is cleared.
- R3: A write to 0x24 sets every source bit written as one. Only bits 24..16, 12..9 and 4..0 exist (implemented mask 0x01FF_1E1F). All other bits, bit 8 included, always read zero.
- R4: A write to 0x28 clears every source bit written as one and leaves the other source bits unchanged.
- R5: A write to 0x30 sets mask bits and a write to 0x34 clears mask bits, under the same implemented-bit mask as the source register.
- R6: Address 0x38 reads the source register ANDed with the mask register.
- R7: Address 0x20, and also 0x24 and 0x28, read the source register. Address 0x2c, and also 0x30 and 0x34, read the mask register. Writes to 0x20, 0x2c and 0x38 change nothing. Address 0x3c and every unmapped address read zero.
- R8: A hardware event that arrives in the same cycle as a source-clear write of the same bit leaves that bit set.
- R9: When the line is armed and any masked source bit is pending, `cpu_irq` is high for exactly one cycle and the line disarms. Afterwards `cpu_irq` stays low, however many bits are pending, until a write to 0x3c (any data) arrives.
- R10: If any masked bit is pending when the end-of-interrupt write happens, `cpu_irq` is high in the cycle after that write. If nothing is pending, the line stays armed and fires one cycle after the first masked bit becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tx_evt | input | 5 | Transmit event pulses, endpoint 0 to 4 |
| rx_evt | input | 4 | Receive event pulses, endpoints 1 to 4 |
| core_evt | input | 9 | Core-level event pulses, the top one being VBUS-drive change |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the CPU |

## Verification
The hardest case to reach is a disarmed line with bits still pending. In that state, events and mask changes must not produce a second pulse, and only the end-of-interrupt write may bring the line back, in the very next cycle. The directed part of the stimulus fires the line, keeps it disarmed while it adds new events and mask bits, and then writes the end-of-interrupt register once with bits pending and once with nothing pending. The exact collision of a hardware event with a clear write of the same bit is also driven on purpose. The random part mixes sparse event pulses with writes to every address, so a disarmed line meets new pending bits many times.

// File: rtl/irq_shadow_pkg.sv
// Package: register offsets, field positions and the write-strobe bundle
// shared by the interrupt shadow block. Assumes byte addresses of 8 bits.
package irq_shadow_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    // Field positions, decoded by software.
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 9;
    localparam int CORE_LSB = 16;

    // Register byte offsets.
    localparam logic [ADDR_W-1:0] OFS_SRC      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_SRC_SET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_SRC_CLR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MSK      = 8'h2c;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_MASKED   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_EOI      = 8'h3c;

    // One-cycle write strobes decoded from the bus.
    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
        logic eoi;
    } wr_strobe_t;

    // Mask of the implemented bits for a given field size.
    function automatic logic [DATA_W-1:0] impl_bits(input int ntx, input int nrx, input int ncore);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < ntx; i++)   m[TX_LSB + i]   = 1'b1;
        for (int i = 0; i < nrx; i++)   m[RX_LSB + i]   = 1'b1;
        for (int i = 0; i < ncore; i++) m[CORE_LSB + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_w1sc_reg.sv
// Module: a register with write-one-to-set and write-one-to-clear ports plus
// hardware set inputs. A hardware set has priority over a clear in the same
// cycle. Bits outside IMPL never become one.
// Assumes set_wr and clr_wr are never both high (one bus write per cycle).
module irq_w1sc_reg #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // Next value: clear first, then software set, then hardware set wins.
    always_comb begin
        nxt = q;
        if (clr_wr) nxt = nxt & ~wdata;
        if (set_wr) nxt = nxt | wdata;
        nxt = (nxt | hw_set) & IMPL;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // A hardware event is never lost, even under a clear write.
    assert_hw_set_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

    // A set write leaves every written implemented bit at one.
    assert_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

    // A clear write without a colliding event leaves the written bits at zero.
    assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((hw_set & wdata) == '0)) |=> ((q & $past(wdata)) == '0));

endmodule

// File: rtl/irq_bus_decode.sv
// Module: decodes bus writes into one-cycle strobes and muxes read data.
// Assumes read data is consumed combinationally in the cycle of the address.
module irq_bus_decode
    import irq_shadow_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] msk,
    output wr_strobe_t        strb,
    output logic [DATA_W-1:0] rdata
);

    // Write strobes: only the set, clear and end-of-interrupt ports act.
    always_comb begin
        strb.src_set = we && (addr == OFS_SRC_SET);
        strb.src_clr = we && (addr == OFS_SRC_CLR);
        strb.msk_set = we && (addr == OFS_MSK_SET);
        strb.msk_clr = we && (addr == OFS_MSK_CLR);
        strb.eoi     = we && (addr == OFS_EOI);
    end

    // Read mux: set and clear ports read back their register.
    always_comb begin
        case (addr)
            OFS_SRC, OFS_SRC_SET, OFS_SRC_CLR: rdata = src;
            OFS_MSK, OFS_MSK_SET, OFS_MSK_CLR: rdata = msk;
            OFS_MASKED:                        rdata = src & msk;
            default:                           rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_eoi_gate.sv
// Module: turns the masked-pending level into a one-cycle CPU pulse, then
// holds the line low until an end-of-interrupt write re-arms it.
// Assumes pending comes from registered state.
module irq_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi_wr,
    output logic irq
);

    logic armed;
    logic fire;

    // Fire when armed, or being re-armed in this cycle, with work pending.
    assign fire = (armed || eoi_wr) && pending;

    // Arm and pulse registers; reset leaves the line armed and low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else begin
            armed <= fire ? 1'b0 : (armed || eoi_wr);
            irq   <= fire;
        end
    end

    // The pulse lasts one cycle unless an end-of-interrupt write refires it.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi_wr) |=> !irq);

    // Without arming and without an end-of-interrupt write the line stays low.
    assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !eoi_wr) |=> !irq);

    // An end-of-interrupt write with work pending fires in the next cycle.
    assert_eoi_refire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && pending) |=> irq);

endmodule

// File: rtl/usb_irq_shadow.sv
// Module: top of the interrupt shadow. Places the event pulses into the source
// register layout, holds source and mask registers with set and clear ports,
// and drives the re-armable CPU interrupt pulse.
// Assumes event inputs are synchronous to clk and field sizes fit the layout.
module usb_irq_shadow
    import irq_shadow_pkg::*;
#(
    parameter int NUM_TX   = 5,
    parameter int NUM_RX   = 4,
    parameter int NUM_CORE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_TX-1:0]   tx_evt,
    input  logic [NUM_RX-1:0]   rx_evt,
    input  logic [NUM_CORE-1:0] core_evt,
    output logic              cpu_irq
);

    localparam logic [DATA_W-1:0] IMPL = impl_bits(NUM_TX, NUM_RX, NUM_CORE);

    logic [DATA_W-1:0] hw_vec;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] msk_q;
    wr_strobe_t        strb;

    // Place each event pulse at its bit in the source layout.
    always_comb begin
        hw_vec = '0;
        for (int i = 0; i < NUM_TX; i++)   hw_vec[TX_LSB + i]   = tx_evt[i];
        for (int i = 0; i < NUM_RX; i++)   hw_vec[RX_LSB + i]   = rx_evt[i];
        for (int i = 0; i < NUM_CORE; i++) hw_vec[CORE_LSB + i] = core_evt[i];
    end

    irq_bus_decode u_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .src   (src_q),
        .msk   (msk_q),
        .strb  (strb),
        .rdata (bus_rdata)
    );

    irq_w1sc_reg #(.W(DATA_W), .IMPL(IMPL)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (strb.src_set),
        .clr_wr (strb.src_clr),
        .wdata  (bus_wdata),
        .hw_set (hw_vec),
        .q      (src_q)
    );

    irq_w1sc_reg #(.W(DATA_W), .IMPL(IMPL)) u_msk (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (strb.msk_set),
        .clr_wr (strb.msk_clr),
        .wdata  (bus_wdata),
        .hw_set ('0),
        .q      (msk_q)
    );

    irq_eoi_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(src_q & msk_q)),
        .eoi_wr  (strb.eoi),
        .irq     (cpu_irq)
    );

    // Reset leaves the registers clear, so the line cannot fire right after it.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_irq && src_q == '0 && msk_q == '0));

endmodule

// File: tb/usb_irq_shadow_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, checked against
// a reference model written from the requirements.
module usb_irq_shadow_bench;

    localparam logic [31:0] IMPL = 32'h01FF_1E1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tx = '0;
    logic [3:0]  rx = '0;
    logic [8:0]  core = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_src = '0, m_msk = '0;
    logic        m_arm = 1'b1, m_irq = 1'b0;

    always #2.5 clk = ~clk;

    usb_irq_shadow u_usb_irq_shadow (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .tx_evt(tx), .rx_evt(rx),
        .core_evt(core), .cpu_irq(irq)
    );

    function automatic logic [31:0] hw_bits(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
        return {7'd0, c, 3'd0, r, 4'd0, t};
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h20, 8'h24, 8'h28: return m_src;
            8'h2c, 8'h30, 8'h34: return m_msk;
            8'h38:               return m_src & m_msk;
            default:             return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h20:        return "R2";
            8'h24:        return "R3";
            8'h28:        return "R4";
            8'h30, 8'h34: return "R5";
            8'h38:        return "R6";
            default:      return "R7";
        endcase
    endfunction

    // Advance the model by one clock edge with the currently driven inputs.
    task automatic model_edge();
        logic pend, eoi, fire;
        if (!rst_n) begin
            m_src = '0; m_msk = '0; m_arm = 1'b1; m_irq = 1'b0;
        end else begin
            pend = |(m_src & m_msk);
            eoi  = we && addr == 8'h3c;
            fire = (m_arm || eoi) && pend;
            m_arm = fire ? 1'b0 : (m_arm || eoi);
            m_irq = fire;
            if (we && addr == 8'h28) m_src = m_src & ~wdata;
            if (we && addr == 8'h24) m_src = m_src | wdata;
            m_src = (m_src | hw_bits(tx, rx, core)) & IMPL;
            if (we && addr == 8'h34) m_msk = m_msk & ~wdata;
            if (we && addr == 8'h30) m_msk = m_msk | wdata;
            m_msk = m_msk & IMPL;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge with inputs driven: check, then clock.
    task automatic step(input string rtag, input string itag);
        #1;
        check(rtag, rdata, model_read(addr));
        check(itag, {31'd0, irq}, {31'd0, m_irq});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic op(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [4:0] t, input logic [3:0] r, input logic [8:0] c,
                      input string rtag, input string itag);
        addr = a; we = w; wdata = d; tx = t; rx = r; core = c;
        step(rtag, itag);
        we = 1'b0; tx = '0; rx = '0; core = '0;
    endtask

    task automatic rd(input logic [7:0] a, input string rtag, input string itag);
        op(a, 1'b0, 32'h0, '0, '0, '0, rtag, itag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        @(negedge clk);
        repeat (3) step("R1", "R1");
        rst_n = 1'b1;
        rd(8'h20, "R1", "R1");
        rd(8'h2c, "R1", "R1");
        // Field placement of each event group.
        op(8'h20, 1'b0, 0, 5'b01000, 4'b0000, 9'h000, "R2", "R2");
        rd(8'h20, "R2", "R2");
        check("R2", rdata, 32'h0000_0008);
        op(8'h20, 1'b0, 0, 5'b00000, 4'b0001, 9'h100, "R2", "R2");
        rd(8'h20, "R2", "R2");
        check("R2", rdata, 32'h0100_0208);
        // Software set with unimplemented bits; bit 8 stays zero.
        op(8'h24, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, "R3", "R3");
        rd(8'h24, "R3", "R3");
        check("R3", rdata, IMPL);
        // Software clear of a few bits.
        op(8'h28, 1'b1, 32'h0000_001F, '0, '0, '0, "R4", "R4");
        rd(8'h28, "R4", "R4");
        check("R4", rdata, 32'h01FF_1E00);
        // Writes to read-only views change nothing.
        op(8'h20, 1'b1, 32'h0, '0, '0, '0, "R7", "R7");
        op(8'h2c, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, "R7", "R7");
        op(8'h38, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, "R7", "R7");
        rd(8'h20, "R7", "R7");
        check("R7", rdata, 32'h01FF_1E00);
        rd(8'h2c, "R7", "R7");
        check("R7", rdata, 32'h0);
        // Event beats a clear of the same bit.
        op(8'h28, 1'b1, 32'h0000_0201, 5'b00001, 4'b0000, 9'h000, "R8", "R8");
        rd(8'h20, "R8", "R8");
        check("R8", rdata & 32'h0000_0201, 32'h0000_0001);
        // Mask, masked view and the first pulse.
        op(8'h30, 1'b1, 32'h0100_0001, '0, '0, '0, "R5", "R9");
        rd(8'h38, "R6", "R9");
        check("R9", {31'd0, irq}, 32'd1);
        rd(8'h38, "R6", "R9");
        check("R6", rdata, 32'h0100_0001);
        check("R9", {31'd0, irq}, 32'd0);
        // Disarmed: new events and mask bits do not refire.
        op(8'h30, 1'b1, 32'h0000_1E00, '0, 4'b1111, '0, "R5", "R9");
        repeat (4) rd(8'h38, "R6", "R9");
        check("R9", {31'd0, irq}, 32'd0);
        // End-of-interrupt with pending work refires on the next cycle.
        op(8'h3c, 1'b1, 32'hDEAD_BEEF, '0, '0, '0, "R7", "R10");
        check("R10", {31'd0, irq}, 32'd1);
        rd(8'h3c, "R7", "R10");
        // Clear everything, re-arm with nothing pending, then one event.
        op(8'h28, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, "R4", "R10");
        op(8'h3c, 1'b1, 32'h0, '0, '0, '0, "R7", "R10");
        rd(8'h38, "R6", "R10");
        check("R10", {31'd0, irq}, 32'd0);
        op(8'h20, 1'b0, 0, '0, 4'b0100, '0, "R10", "R10");
        rd(8'h38, "R6", "R10");
        check("R10", {31'd0, irq}, 32'd1);
        rd(8'h38, "R6", "R10");
        // Seeded random traffic.
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = 8'h20 + 8'(4 * ($urandom % 10));
            d = ($urandom % 3 == 0) ? $urandom : (32'h1 << ($urandom % 32));
            op(a, ($urandom % 3 != 0), d,
               ($urandom % 8 == 0) ? 5'(1 << ($urandom % 5)) : 5'd0,
               ($urandom % 8 == 0) ? 4'(1 << ($urandom % 4)) : 4'd0,
               ($urandom % 8 == 0) ? 9'(1 << ($urandom % 9)) : 9'd0,
               tag_of(a), "R9");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule